// File: doc/BRIEF.md
# Fractional SPI Clock Generator

This block makes the serial clock for a SPI master out of a faster reference clock. The clock is not divided by an integer counter. An 11-bit phase accumulator (modulo 2048) adds an increment on every reference cycle while a transfer runs. Each carry out of the accumulator ends one half-period of the serial clock, and the serial clock toggles there. The increment comes from a 16-bit frequency word, so the serial rate is a fraction of the reference rate: one full period lasts 4096/increment reference cycles on average.

The shift engine picks one of several target profiles. Each profile holds its own frequency word, a doubled-rate option, an option that clears the accumulator when a transfer starts, the edge direction used to launch data, the edge direction used to sample data, and a request for the asynchronous input path. A global polarity input sets the level the serial clock rests at. A global gating input stops the clock whenever no target is selected. Alongside the clock the block gives one-cycle launch and sample strobes that line up with the serial clock edges. It also gives a registered flag for the input-path choice. All of these are quiet outside an active transfer.

Top module: `spi_frac_clkgen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, sclk_o equals cpol_i, and launch_o, sample_o and async_sel_o are 0.
- R2: While the generator is inactive, sclk_o rests at cpol_i. It returns there one cycle after xfer_run_i falls. The first edge of a transfer moves sclk_o away from cpol_i.
- R3: With the accumulator cleared at the start, sclk_o changes floor(N*inc/2048) times in the first N reference cycles of a transfer. inc is the profile's frequency word, limited to 2048.
- R4: A frequency word of 0 keeps sclk_o at cpol_i for the whole transfer, with no strobes.
- R5: When the doubled-rate bit of the profile is set, inc is twice the frequency word, limited to 2048.
- R6: When the accumulator-reset bit is set, the accumulator starts from 0 on the first cycle of a transfer. When it is clear, the accumulator carries on from the value left by the previous transfer. Between transfers the accumulator holds its value.
- R7: launch_o pulses for one cycle in exactly those cycles in which sclk_o has just changed to level 1 (if the profile's launch-rising bit is 1) or to level 0 (if that bit is 0).
- R8: sample_o follows the same rule as R7, using the profile's sample-rising bit.
- R9: The generator is active when xfer_run_i is 1 and either gate_idle_i is 0 or any_tgt_i is 1. With gate_idle_i at 1 and any_tgt_i at 0 the clock stays idle.
- R10: prof_sel_i picks which profile's fields are used. Profile k occupies bits [16k+15:16k] of prof_freq_i and bit k of each per-profile flag vector.
- R11: async_sel_o is 1 in the cycle after an active cycle in which the selected profile's asynchronous-path bit is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_run_i | input | 1 | Transfer in progress |
| any_tgt_i | input | 1 | Some target is selected |
| gate_idle_i | input | 1 | Stop the clock when no target is selected |
| cpol_i | input | 1 | Idle level of the serial clock |
| prof_sel_i | input | 2 | Active profile index |
| prof_freq_i | input | 64 | Frequency words, 16 bits per profile |
| prof_accrst_i | input | 4 | Clear accumulator at transfer start, per profile |
| prof_x2_i | input | 4 | Doubled-rate mode, per profile |
| prof_launch_rise_i | input | 4 | Launch on rising edge, per profile |
| prof_sample_rise_i | input | 4 | Sample on rising edge, per profile |
| prof_async_i | input | 4 | Asynchronous input path request, per profile |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Launch strobe, one cycle per launch edge |
| sample_o | output | 1 | Sample strobe, one cycle per sample edge |
| async_sel_o | output | 1 | Asynchronous input path selected |

## Verification
Each result lags its stimulus by exactly one register stage. A carry on reference edge k shows on sclk_o and on the strobes after edge k, so the k-th cycle of a transfer is judged at the falling reference edge that follows the k-th rising edge after xfer_run_i was raised. The bench drives inputs and samples outputs only at falling edges. It therefore counts serial-clock changes over a window of exactly N rising edges and compares that count with floor(N*inc/2048). Idle return and async_sel_o are checked one falling edge after the change that should cause them, and first-edge timing is checked by the count reached within two or three cycles.

// File: rtl/spi_fcg_pkg.sv
package spi_fcg_pkg;
  // Per-profile option bits, gathered once the profile has been chosen
  typedef struct packed {
    logic acc_rst;
    logic x2;
    logic launch_rise;
    logic sample_rise;
    logic async_in;
  } prof_flags_t;
endpackage

// File: rtl/fcg_prof_mux.sv
module fcg_prof_mux
  import spi_fcg_pkg::*;
#(
  parameter int NPROF  = 4,
  parameter int FREQ_W = 16,
  localparam int SelW  = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic [SelW-1:0]         sel_i,
  input  logic [NPROF*FREQ_W-1:0] freq_i,
  input  logic [NPROF-1:0]        accrst_i,
  input  logic [NPROF-1:0]        x2_i,
  input  logic [NPROF-1:0]        launch_rise_i,
  input  logic [NPROF-1:0]        sample_rise_i,
  input  logic [NPROF-1:0]        async_i,
  output logic [FREQ_W-1:0]       freq_o,
  output prof_flags_t             flags_o
);
  logic [FREQ_W-1:0] freq_arr  [NPROF];
  prof_flags_t       flags_arr [NPROF];

  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    assign freq_arr[p]  = freq_i[p*FREQ_W +: FREQ_W];
    assign flags_arr[p] = '{acc_rst:     accrst_i[p],
                            x2:          x2_i[p],
                            launch_rise: launch_rise_i[p],
                            sample_rise: sample_rise_i[p],
                            async_in:    async_i[p]};
  end

  always_comb begin
    freq_o  = '0;
    flags_o = '0;
    for (int p = 0; p < NPROF; p++) begin
      if (sel_i == SelW'(p)) begin
        freq_o  = freq_arr[p];
        flags_o = flags_arr[p];
      end
    end
  end
endmodule

// File: rtl/fcg_phase_acc.sv
module fcg_phase_acc #(
  parameter int FREQ_W = 16,
  parameter int ACC_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              acc_rst_i,
  input  logic              x2_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              wrap_o
);
  localparam logic [FREQ_W:0] FullWide = (FREQ_W+1)'(1) << ACC_W;
  localparam logic [ACC_W:0]  FullInc  = (ACC_W+1)'(1) << ACC_W;

  logic [ACC_W-1:0] acc_q, acc_d, base;
  logic [FREQ_W:0]  scaled;
  logic [ACC_W:0]   inc, sum;

  always_comb begin
    scaled = x2_i ? {freq_i, 1'b0} : {1'b0, freq_i};
    inc    = (scaled >= FullWide) ? FullInc : scaled[ACC_W:0];
    base   = (start_i && acc_rst_i) ? '0 : acc_q;
    sum    = {1'b0, base} + inc;
    wrap_o = en_i & sum[ACC_W];
    acc_d  = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/fcg_edge_gen.sv
module fcg_edge_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  input  logic cpol_i,
  input  logic launch_rise_i,
  input  logic sample_rise_i,
  input  logic async_in_i,
  output logic sclk_o,
  output logic launch_o,
  output logic sample_o,
  output logic async_sel_o
);
  logic phase_q, phase_d;
  logic launch_q, launch_d;
  logic sample_q, sample_d;
  logic async_q, async_d;
  logic lvl_next;

  always_comb begin
    lvl_next = cpol_i ^ ~phase_q;
    phase_d  = en_i ? (phase_q ^ wrap_i) : 1'b0;
    launch_d = wrap_i & (lvl_next == launch_rise_i);
    sample_d = wrap_i & (lvl_next == sample_rise_i);
    async_d  = en_i & async_in_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
      async_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      launch_q <= launch_d;
      sample_q <= sample_d;
      async_q  <= async_d;
    end
  end

  assign sclk_o      = cpol_i ^ phase_q;
  assign launch_o    = launch_q;
  assign sample_o    = sample_q;
  assign async_sel_o = async_q;
endmodule

// File: rtl/spi_frac_clkgen.sv
module spi_frac_clkgen
  import spi_fcg_pkg::*;
#(
  parameter int NPROF  = 4,
  parameter int FREQ_W = 16,
  parameter int ACC_W  = 11,
  localparam int SelW  = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xfer_run_i,
  input  logic                    any_tgt_i,
  input  logic                    gate_idle_i,
  input  logic                    cpol_i,
  input  logic [SelW-1:0]         prof_sel_i,
  input  logic [NPROF*FREQ_W-1:0] prof_freq_i,
  input  logic [NPROF-1:0]        prof_accrst_i,
  input  logic [NPROF-1:0]        prof_x2_i,
  input  logic [NPROF-1:0]        prof_launch_rise_i,
  input  logic [NPROF-1:0]        prof_sample_rise_i,
  input  logic [NPROF-1:0]        prof_async_i,
  output logic                    sclk_o,
  output logic                    launch_o,
  output logic                    sample_o,
  output logic                    async_sel_o
);
  logic [FREQ_W-1:0] freq_sel;
  prof_flags_t       flags_sel;
  logic              en, run_q, start, wrap;

  assign en    = xfer_run_i & (~gate_idle_i | any_tgt_i);
  assign start = en & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en;
  end

  fcg_prof_mux #(.NPROF(NPROF), .FREQ_W(FREQ_W)) u_mux (
    .sel_i         (prof_sel_i),
    .freq_i        (prof_freq_i),
    .accrst_i      (prof_accrst_i),
    .x2_i          (prof_x2_i),
    .launch_rise_i (prof_launch_rise_i),
    .sample_rise_i (prof_sample_rise_i),
    .async_i       (prof_async_i),
    .freq_o        (freq_sel),
    .flags_o       (flags_sel)
  );

  fcg_phase_acc #(.FREQ_W(FREQ_W), .ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .start_i   (start),
    .acc_rst_i (flags_sel.acc_rst),
    .x2_i      (flags_sel.x2),
    .freq_i    (freq_sel),
    .wrap_o    (wrap)
  );

  fcg_edge_gen u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en),
    .wrap_i        (wrap),
    .cpol_i        (cpol_i),
    .launch_rise_i (flags_sel.launch_rise),
    .sample_rise_i (flags_sel.sample_rise),
    .async_in_i    (flags_sel.async_in),
    .sclk_o        (sclk_o),
    .launch_o      (launch_o),
    .sample_o      (sample_o),
    .async_sel_o   (async_sel_o)
  );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic xfer_run_i,
  input logic any_tgt_i,
  input logic gate_idle_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic launch_o,
  input logic sample_o,
  input logic async_sel_o
);
  logic active;
  assign active = xfer_run_i & (~gate_idle_i | any_tgt_i);

  // R2 / R9: an inactive cycle leaves the clock at its idle level
  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (sclk_o == cpol_i));

  // R7: a launch strobe marks a clock change that came from an active cycle
  a_r7_launch_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o && $stable(cpol_i)) |-> ((sclk_o != $past(sclk_o)) && $past(active)));

  // R8: a sample strobe marks a clock change that came from an active cycle
  a_r8_sample_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $stable(cpol_i)) |-> ((sclk_o != $past(sclk_o)) && $past(active)));

  // R11: path selection only follows an active cycle
  a_r11_async_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_sel_o |-> $past(active));
endmodule

bind spi_frac_clkgen fcg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_run_i  (xfer_run_i),
  .any_tgt_i   (any_tgt_i),
  .gate_idle_i (gate_idle_i),
  .cpol_i      (cpol_i),
  .sclk_o      (sclk_o),
  .launch_o    (launch_o),
  .sample_o    (sample_o),
  .async_sel_o (async_sel_o)
);

// File: tb/sim_spi_frac_clkgen.sv
`timescale 1ns/1ps
module sim_spi_frac_clkgen;
  localparam int NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, any_tgt = 1'b1, gate = 1'b0, cpol = 1'b0;
  logic [1:0] psel = '0;
  logic [NP*16-1:0] pfreq = '0;
  logic [NP-1:0] paccrst = '1, px2 = '0, plr = '0, psr = '1, pasync = '0;
  logic sclk, launch, sample, asel;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_frac_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .xfer_run_i(run), .any_tgt_i(any_tgt),
    .gate_idle_i(gate), .cpol_i(cpol), .prof_sel_i(psel), .prof_freq_i(pfreq),
    .prof_accrst_i(paccrst), .prof_x2_i(px2), .prof_launch_rise_i(plr),
    .prof_sample_rise_i(psr), .prof_async_i(pasync),
    .sclk_o(sclk), .launch_o(launch), .sample_o(sample), .async_sel_o(asel));

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Runs n active cycles; counts clock changes and strobe mismatches (R7, R8)
  task automatic run_window(int n, output int toggles, output int bad_l, output int bad_s);
    logic prev;
    bit exp_l, exp_s;
    toggles = 0; bad_l = 0; bad_s = 0;
    prev = sclk;
    run = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp_l = (sclk != prev) && (sclk == plr[psel]);
      exp_s = (sclk != prev) && (sclk == psr[psel]);
      if (sclk != prev) toggles++;
      if (launch != exp_l) bad_l++;
      if (sample != exp_s) bad_s++;
      prev = sclk;
    end
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_freq(int p, int f);
    pfreq[p*16 +: 16] = 16'(f);
  endtask

  task automatic t_reset();
    chk("R1 sclk in reset", sclk, cpol);
    chk("R1 launch in reset", launch, 0);
    chk("R1 sample in reset", sample, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sclk after reset", sclk, 0);
    chk("R1 async after reset", asel, 0);
  endtask

  task automatic t_rate();
    int t, bl, bs;
    psel = 0;
    set_freq(0, 2048); run_window(64, t, bl, bs); chk("R3 inc 2048", t, 64);
    set_freq(0, 1024); run_window(64, t, bl, bs); chk("R3 inc 1024", t, 32);
    set_freq(0, 768);  run_window(64, t, bl, bs); chk("R3 inc 768", t, 24);
    set_freq(0, 5000); run_window(40, t, bl, bs); chk("R3 clamp", t, 40);
    chk("R2 back to idle", sclk, cpol);
  endtask

  task automatic t_zero();
    int t, bl, bs;
    set_freq(0, 0); run_window(50, t, bl, bs);
    chk("R4 zero toggles", t, 0);
    chk("R4 zero launch", bl, 0);
  endtask

  task automatic t_x2();
    int t, bl, bs;
    set_freq(0, 512); px2[0] = 1'b1; run_window(64, t, bl, bs);
    chk("R5 doubled", t, 32);
    set_freq(0, 1500); run_window(32, t, bl, bs);
    chk("R5 doubled clamp", t, 32);
    px2[0] = 1'b0;
  endtask

  task automatic t_accrst();
    int t, bl, bs;
    set_freq(0, 768); paccrst[0] = 1'b1;
    run_window(4, t, bl, bs);   // leaves accumulator at 1024
    chk("R6 prime", t, 1);
    paccrst[0] = 1'b0;
    run_window(2, t, bl, bs);   // 1792, then carry
    chk("R6 carry on", t, 1);
    paccrst[0] = 1'b1;
    run_window(2, t, bl, bs);   // 768, 1536: no carry
    chk("R6 cleared", t, 0);
  endtask

  task automatic t_edges();
    int t, bl, bs;
    set_freq(0, 1024);
    for (int c = 0; c < 2; c++) begin
      cpol = 1'(c); @(negedge clk);
      chk("R2 idle follows cpol", sclk, c);
      plr[0] = 1'b1; psr[0] = 1'b0;
      run = 1'b1; @(negedge clk); @(negedge clk);
      chk("R2 first edge leaves idle", sclk, 1 - c);
      run = 1'b0; @(negedge clk);
      run_window(40, t, bl, bs);
      chk("R7 launch rising", bl, 0);
      chk("R8 sample falling", bs, 0);
      plr[0] = 1'b0; psr[0] = 1'b0;
      run_window(40, t, bl, bs);
      chk("R7 launch falling", bl, 0);
      chk("R8 sample falling same", bs, 0);
    end
    cpol = 1'b0; @(negedge clk);
  endtask

  task automatic t_gate();
    int t, bl, bs;
    set_freq(0, 2048);
    gate = 1'b1; any_tgt = 1'b0; run_window(16, t, bl, bs);
    chk("R9 gated stop", t, 0);
    any_tgt = 1'b1; run_window(16, t, bl, bs);
    chk("R9 gated with target", t, 16);
    gate = 1'b0; any_tgt = 1'b0; run_window(16, t, bl, bs);
    chk("R9 ungated", t, 16);
    any_tgt = 1'b1;
  endtask

  task automatic t_profile();
    int t, bl, bs;
    set_freq(1, 2048); set_freq(2, 512); set_freq(3, 0);
    psel = 2; run_window(64, t, bl, bs); chk("R10 profile 2", t, 16);
    psel = 3; run_window(20, t, bl, bs); chk("R10 profile 3", t, 0);
    psel = 1; run_window(20, t, bl, bs); chk("R10 profile 1", t, 20);
  endtask

  task automatic t_async();
    pasync[1] = 1'b1; psel = 1;
    run = 1'b1; @(negedge clk);
    chk("R11 async set", asel, 1);
    psel = 0; @(negedge clk);
    chk("R11 async other profile", asel, 0);
    psel = 1; @(negedge clk);
    run = 1'b0; @(negedge clk);
    chk("R11 async idle", asel, 0);
  endtask

  initial begin
    #3;
    t_reset();
    t_rate();
    t_zero();
    t_x2();
    t_accrst();
    t_edges();
    t_gate();
    t_profile();
    t_async();
    report();
  end

  initial begin
    #(4 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule